// File: doc/BRIEF.md
# Supervisor-Call Exception Entry Unit

This unit sits at the retire point of a 32-bit processor core and performs the architectural state change for a supervisor call, a software-triggered exception. On every retiring instruction it checks the encoding. When the instruction is a supervisor call whose condition check passed and no higher-priority exception is pending, the unit performs one atomic update. The supervisor link register gets the return address and the supervisor saved status register gets the old status word. The live status word switches to supervisor mode with IRQs masked, and the program counter goes to the vector base plus 8. A one-cycle redirect strobe tells fetch to restart at the new program counter. The 24-bit call number is kept so that a handler can read it.

A retiring instruction that is not a supervisor call, or that failed its condition check, only advances the program counter by 4 and passes the status word through. A pending higher-priority exception, signalled on a stub input, cancels the retire and leaves all state unchanged. All results are registered and appear one cycle after the retire cycle.

Top module: `svc_entry`

## Requirements
- R1: An instruction is a supervisor call when bits 27..24 are 4'b1111. Entry is taken when `valid_i`, `cond_pass_i` and the encoding match are all true and `hi_exc_i` is low. `redirect_o` is high in the cycle after such a retire and low in every other cycle.
- R2: On entry, `lr_svc_o` becomes `pc_i + 4`, wrapping modulo 2^32.
- R3: On entry, `spsr_svc_o` becomes the value `cpsr_i` had in the retire cycle.
- R4: On entry, `pc_o` becomes `vbase_i + 8`.
- R5: On entry, `cpsr_o[4:0]` becomes 5'b10011 (supervisor mode) and `cpsr_o[7]` (the IRQ mask) becomes 1.
- R6: On entry, `cpsr_o[31:8]` and `cpsr_o[6:5]` equal the same bits of `cpsr_i`, so the flags, the FIQ mask (bit 6) and the state bit (bit 5) are kept.
- R7: A retire whose condition check failed acts as a no-op. `pc_o` becomes `pc_i + 4`, `cpsr_o` becomes `cpsr_i`, `lr_svc_o`, `spsr_svc_o` and `svc_num_o` keep their values, and there is no redirect.
- R8: A retire of any instruction whose bits 27..24 are not 4'b1111 behaves the same as in R7, even when its condition check passed.
- R9: Each taken entry gives exactly one high cycle of `redirect_o`, and `redirect_o` is high only together with `done_o`. Back-to-back entries give one pulse each.
- R10: When `hi_exc_i` is high in a retire cycle, `done_o` stays low in the next cycle and every state output keeps its value.
- R11: After reset, `pc_o`, `lr_svc_o`, `spsr_svc_o` and `svc_num_o` are 0, `cpsr_o` is 32'h0000_00D3, and `done_o` and `redirect_o` are low.
- R12: On entry, `svc_num_o` becomes instruction bits 23..0. Otherwise it holds its value.
- R13: `done_o` is high in the cycle after each retire with `hi_exc_i` low, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction retires this cycle |
| instr_i | input | 32 | Encoding of the retiring instruction |
| cond_pass_i | input | 1 | Condition check result of the retiring instruction |
| pc_i | input | 32 | Address of the retiring instruction |
| cpsr_i | input | 32 | Current status word |
| vbase_i | input | 32 | Exception vector base |
| hi_exc_i | input | 1 | Higher-priority exception pending; cancels the retire |
| pc_o | output | 32 | Next program counter |
| cpsr_o | output | 32 | Updated status word |
| lr_svc_o | output | 32 | Supervisor link register |
| spsr_svc_o | output | 32 | Supervisor saved status register |
| svc_num_o | output | 24 | Call number of the last entry |
| done_o | output | 1 | Retire result is valid |
| redirect_o | output | 1 | One-cycle strobe to fetch on entry |

## Verification
All state lives in output registers, so any fault in the update shows up one cycle after the retire that caused it. A wrong decode shows up as a missing or extra `redirect_o` together with a `pc_o` that is off by either the vector offset or the 4-byte step. A mask that touches the wrong status bits shows up at once as a flag, FIQ or state bit that differs from the input. Banked registers that are written when they should not be stay wrong until the next entry overwrites them. For that reason the idle cycles and cancelled retires are compared against the last expected values as well.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int XLEN      = 32;
  localparam int IMM_W     = 24;
  localparam int CLS_W     = 4;
  localparam int MODE_W    = 5;
  localparam int IRQ_BIT   = 7;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [CLS_W-1:0]  CLS_SVC  = 4'b1111;
  localparam logic [XLEN-1:0]   INSN_STEP = 32'd4;

  typedef struct packed {
    logic [XLEN-1:0]  pc;
    logic [XLEN-1:0]  cpsr;
    logic [XLEN-1:0]  lr;
    logic [XLEN-1:0]  spsr;
    logic [IMM_W-1:0] num;
  } arch_upd_t;
endpackage

// File: rtl/svc_decode.sv
module svc_decode
  import svc_pkg::*;
(
  input  logic [XLEN-1:0]  instr_i,
  output logic             is_svc_o,
  output logic [IMM_W-1:0] imm_o
);
  localparam int CLS_LSB = IMM_W;
  localparam int CLS_MSB = IMM_W + CLS_W - 1;

  // condition field is resolved upstream; only the class and immediate matter here
  logic unused_cond;
  assign unused_cond = ^instr_i[XLEN-1:CLS_MSB+1];

  assign is_svc_o = (instr_i[CLS_MSB:CLS_LSB] == CLS_SVC);
  assign imm_o    = instr_i[IMM_W-1:0];
endmodule

// File: rtl/svc_next.sv
module svc_next
  import svc_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_OFS = 32'h8
) (
  input  logic             take_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  cpsr_i,
  input  logic [XLEN-1:0]  vbase_i,
  input  logic [IMM_W-1:0] imm_i,
  output arch_upd_t        upd_o
);
  logic [XLEN-1:0] cpsr_svc;

  // mode and IRQ mask forced, all other bits kept
  assign cpsr_svc = {cpsr_i[XLEN-1:IRQ_BIT+1], 1'b1, cpsr_i[IRQ_BIT-1:MODE_W], MODE_SVC};

  always_comb begin
    upd_o.lr   = pc_i + INSN_STEP;
    upd_o.spsr = cpsr_i;
    upd_o.num  = imm_i;
    upd_o.pc   = take_i ? (vbase_i + VEC_OFS) : (pc_i + INSN_STEP);
    upd_o.cpsr = take_i ? cpsr_svc : cpsr_i;
  end
endmodule

// File: rtl/svc_entry.sv
module svc_entry
  import svc_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_OFS  = 32'h8,
  parameter logic [XLEN-1:0] RST_PC   = '0,
  parameter logic [XLEN-1:0] RST_CPSR = 32'h0000_00D3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic             cond_pass_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  cpsr_i,
  input  logic [XLEN-1:0]  vbase_i,
  input  logic             hi_exc_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  cpsr_o,
  output logic [XLEN-1:0]  lr_svc_o,
  output logic [XLEN-1:0]  spsr_svc_o,
  output logic [IMM_W-1:0] svc_num_o,
  output logic             done_o,
  output logic             redirect_o
);
  logic             is_svc;
  logic [IMM_W-1:0] imm;
  logic             retire;
  logic             take;
  arch_upd_t        upd;

  svc_decode u_dec (
    .instr_i (instr_i),
    .is_svc_o(is_svc),
    .imm_o   (imm)
  );

  assign retire = valid_i && !hi_exc_i;
  assign take   = retire && cond_pass_i && is_svc;

  svc_next #(.VEC_OFS(VEC_OFS)) u_nxt (
    .take_i (take),
    .pc_i   (pc_i),
    .cpsr_i (cpsr_i),
    .vbase_i(vbase_i),
    .imm_i  (imm),
    .upd_o  (upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= RST_PC;
      cpsr_o     <= RST_CPSR;
      lr_svc_o   <= '0;
      spsr_svc_o <= '0;
      svc_num_o  <= '0;
      done_o     <= 1'b0;
      redirect_o <= 1'b0;
    end else begin
      done_o     <= retire;
      redirect_o <= take;
      if (retire) begin
        pc_o   <= upd.pc;
        cpsr_o <= upd.cpsr;
      end
      if (take) begin
        lr_svc_o   <= upd.lr;
        spsr_svc_o <= upd.spsr;
        svc_num_o  <= upd.num;
      end
    end
  end
endmodule

// File: rtl/svc_entry_chk.sv
module svc_entry_chk
  import svc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [XLEN-1:0]  instr_i,
  input logic             cond_pass_i,
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  cpsr_i,
  input logic [XLEN-1:0]  vbase_i,
  input logic             hi_exc_i,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  cpsr_o,
  input logic [XLEN-1:0]  lr_svc_o,
  input logic [XLEN-1:0]  spsr_svc_o,
  input logic [IMM_W-1:0] svc_num_o,
  input logic             done_o,
  input logic             redirect_o
);
  logic ent;
  assign ent = valid_i && !hi_exc_i && cond_pass_i && (instr_i[27:24] == 4'hF);

  // R1
  take_redir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> redirect_o);
  // R2
  link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> lr_svc_o == $past(pc_i) + 32'd4);
  // R3
  save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> spsr_svc_o == $past(cpsr_i));
  // R4
  vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> pc_o == $past(vbase_i) + 32'd8);
  // R5
  mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> (cpsr_o[4:0] == 5'b10011) && cpsr_o[7]);
  // R7
  cond_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hi_exc_i && !cond_pass_i) |=> (pc_o == $past(pc_i) + 32'd4) && !redirect_o);
  // R9
  redir_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> done_o);
  // R10
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hi_exc_i) |=> !done_o && $stable(pc_o) && $stable(lr_svc_o));
  // R12
  num_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> svc_num_o == $past(instr_i[23:0]));
endmodule

bind svc_entry svc_entry_chk u_chk (.*);

// File: tb/sim_svc_entry.sv
`timescale 1ns/1ps
module sim_svc_entry;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] cpsr_i = '0;
  logic [31:0] vbase_i = '0;
  logic        hi_exc_i = 1'b0;
  logic [31:0] pc_o, cpsr_o, lr_svc_o, spsr_svc_o;
  logic [23:0] svc_num_o;
  logic        done_o, redirect_o;

  always #2.5 clk_i = ~clk_i;

  svc_entry u0 (.*);

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] cpsr;
    logic [31:0] lr;
    logic [31:0] spsr;
    logic [23:0] num;
    logic        redir;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  bit   mon_en = 1'b0;
  logic [31:0] m_lr = '0, m_spsr = '0;
  logic [23:0] m_num = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] ins, logic cnd, logic [31:0] pc, logic [31:0] ps,
                       logic [31:0] vb, logic hi);
    exp_t e;
    logic take;
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = ins; cond_pass_i = cnd; pc_i = pc;
    cpsr_i = ps; vbase_i = vb; hi_exc_i = hi;
    take = !hi && cnd && (ins[27:24] == 4'hF);
    if (take) begin
      m_lr = pc + 32'd4; m_spsr = ps; m_num = ins[23:0];
    end
    e.pc    = take ? vb + 32'd8 : pc + 32'd4;
    e.cpsr  = take ? {ps[31:8], 1'b1, ps[6:5], 5'b10011} : ps;
    e.lr    = m_lr;
    e.spsr  = m_spsr;
    e.num   = m_num;
    e.redir = take;
    if (!hi) q.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk_i);
    valid_i = 1'b0; hi_exc_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: pop expected results as done_o appears; hold last otherwise
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (done_o) begin
        if (q.size() == 0) begin
          chk("R13 done without retire", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R4/R7/R8 pc_o", pc_o, e.pc);
          chk("R5/R6 cpsr_o", cpsr_o, e.cpsr);
          chk("R2 lr_svc_o", lr_svc_o, e.lr);
          chk("R3 spsr_svc_o", spsr_svc_o, e.spsr);
          chk("R12 svc_num_o", {8'h0, svc_num_o}, {8'h0, e.num});
          chk("R1/R9 redirect_o", {31'h0, redirect_o}, {31'h0, e.redir});
          last = e;
        end
      end else begin
        chk("R9 redirect idle", {31'h0, redirect_o}, 32'd0);
        chk("R10 pc hold", pc_o, last.pc);
        chk("R10 cpsr hold", cpsr_o, last.cpsr);
        chk("R10 lr hold", lr_svc_o, last.lr);
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 pc_o", pc_o, 32'h0);
    chk("R11 cpsr_o", cpsr_o, 32'h0000_00D3);
    chk("R11 lr_svc_o", lr_svc_o, 32'h0);
    chk("R11 spsr_svc_o", spsr_svc_o, 32'h0);
    chk("R11 svc_num_o", {8'h0, svc_num_o}, 32'h0);
    chk("R11 done/redirect", {30'h0, done_o, redirect_o}, 32'h0);
    last = '{pc: 32'h0, cpsr: 32'h0000_00D3, lr: 32'h0, spsr: 32'h0, num: 24'h0, redir: 1'b0};
    rst_ni = 1'b1;
    @(negedge clk_i);
    mon_en = 1'b1;

    // R1 R2 R3 R4 R5 R6 R12: call from user mode, V flag set
    drive(32'hEF12_3456, 1'b1, 32'h0000_8000, 32'h1000_0010, 32'h0, 1'b0);
    idle(1);
    // R4 nonzero vector base
    drive(32'hEF00_0001, 1'b1, 32'h0000_9000, 32'h6000_0010, 32'hFFFF_0000, 1'b0);
    idle(1);
    // R6 FIQ mask and state bit kept, all flags set
    drive(32'hEF00_0042, 1'b1, 32'h0000_A000, 32'hF800_0070, 32'h0, 1'b0);
    idle(1);
    // R7 condition failed
    drive(32'h0F00_0080, 1'b0, 32'h0000_B000, 32'h2000_0010, 32'h0, 1'b0);
    // R8 non-call instruction with condition passed
    drive(32'hE1A0_0000, 1'b1, 32'h0000_B004, 32'h4000_0010, 32'h0, 1'b0);
    idle(1);
    // R10 cancelled by higher-priority exception
    drive(32'hEF00_0099, 1'b1, 32'h0000_C000, 32'h0000_0010, 32'h0, 1'b1);
    idle(2);
    // R9 back-to-back entries, one pulse each
    drive(32'hEF00_0002, 1'b1, 32'h0000_D000, 32'h0000_0010, 32'h0, 1'b0);
    drive(32'hEF00_0003, 1'b1, 32'h0000_D004, 32'h0000_0093, 32'h0, 1'b0);
    idle(1);
    // R2 link wraps
    drive(32'hEFFF_FFFF, 1'b1, 32'hFFFF_FFFC, 32'h8000_0010, 32'h0, 1'b0);
    idle(2);

    // R13 every retire produced a result
    chk("R13 pending results", q.size(), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule